// File: doc/BRIEF.md
# Single-Register I2C Slave Front End

This block is the serial front end of a small control chip. It listens on an I2C bus for one device address and gives the master access to a single 8-bit control/status register. The block never passes a partial or doubtful write to the register core. A write must select the register with a pointer byte of FFh, carry exactly one data byte, and close with STOP. The block then raises a one-clock commit strobe with that byte.

Both bus lines are sampled by the system clock through a two-flop synchroniser. START and STOP are SDA edges seen while SCL is high. The slave only ever pulls SDA low, through an open-drain enable output. It never holds SCL.

A read is a random read. The master writes the pointer FFh, issues a repeated START with the read bit set, and clocks out one byte of the core's register value. After that single byte the slave goes idle until the next START. The master is expected to close the transaction with STOP.

Top module: `ctlreg_i2c_slave`

## Requirements
- R1: START (SDA falling while SCL is high) restarts address reception from any state, including the middle of a byte. STOP (SDA rising while SCL is high) returns the slave to idle. Both lines pass through two synchroniser flops before detection.
- R2: The first byte after START is received MSB first. Bits 7:1 are compared with 7'b1010010, and bit 0 is the direction (0 = write, 1 = read). On a match the slave pulls SDA low through the ninth SCL pulse. On a mismatch it leaves SDA released for the rest of the transaction.
- R3: In a write, the byte that follows the device address is the register pointer. FFh is acknowledged. Any other value is refused with a released SDA, and every later byte is ignored until the next START.
- R4: The first data byte after the pointer is acknowledged and held. The STOP that follows produces a commit strobe (wr_commit_o) high for exactly one clock, with the byte on wr_data_o.
- R5: A second data byte in the same write is refused (SDA released on its ninth pulse) and the held byte is discarded, so the closing STOP produces no commit.
- R6: A held data byte is committed only by STOP. A repeated START discards it.
- R7: A read address (A5h) that follows an accepted FFh pointer earlier in the same transaction is acknowledged. The slave then drives reg_rdata MSB first, changing SDA only while SCL is low.
- R8: After one read byte and its ninth pulse, the slave releases SDA and ignores the bus until the next START. A read address with no pointer accepted since the last STOP or completed read is refused.
- R9: Read transactions never produce a commit strobe.
- R10: After reset, SDA is released and wr_commit_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| reg_rdata | input | 8 | Current register value from the core, returned on reads |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| wr_commit_o | output | 1 | One-clock strobe: write the byte into the register |
| wr_data_o | output | 8 | Data byte that goes with the commit strobe |

## Verification
The bench targets these cases:
- A second data byte before STOP. A design that miscounts bytes would acknowledge it or still commit.
- A repeated START between a data byte and STOP. A design that commits early would leak the first byte into the register.
- A START in the middle of a byte. A slave that keeps its bit count would shift the next address out of alignment and refuse it.
- A read with no pointer. A careless slave would answer it.
- Bytes clocked after a finished read without a new START. A careless slave would answer those too.
- Wrong device and pointer values. For each of them, the bench checks that SDA stays released during every later bit.

// File: rtl/ctlreg_i2c_pkg.sv
package ctlreg_i2c_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    localparam logic [6:0]        DEV_ADDR = 7'b1010010;
    localparam logic [BYTE_W-1:0] SEL_CODE = 8'hFF;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_REG,
        PH_WDATA,
        PH_WEXTRA,
        PH_RDATA,
        PH_RDONE,
        PH_SKIP
    } phase_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_evt_t;

    function automatic logic dev_hit(logic [BYTE_W-1:0] b);
        return b[BYTE_W-1:1] == DEV_ADDR;
    endfunction

    // bit to put on the line after idx bits of b have gone out
    function automatic logic tx_bit(logic [BYTE_W-1:0] b, logic [CNT_W-1:0] idx);
        logic [BYTE_W-1:0] s;
        s = b << idx;
        return s[BYTE_W-1];
    endfunction

endpackage

// File: rtl/ctlreg_i2c_sync.sv
module ctlreg_i2c_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] d,
    output logic [LINES-1:0] q
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], d[g]};
        end
        assign q[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/ctlreg_i2c_events.sv
module ctlreg_i2c_events
    import ctlreg_i2c_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        evt.start = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop  = scl_s & scl_q & ~sda_q & sda_s;
        evt.rise  = scl_s & ~scl_q;
        evt.fall  = ~scl_s & scl_q;
        evt.sda   = sda_s;
    end
endmodule

// File: rtl/ctlreg_i2c_engine.sv
module ctlreg_i2c_engine
    import ctlreg_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_low,
    output logic              commit,
    output logic [BYTE_W-1:0] commit_data
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    phase_t            phase;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txbuf;
    logic              ack_slot;
    logic              pend;
    logic              sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_IDLE;
            cnt         <= '0;
            shreg       <= '0;
            txbuf       <= '0;
            ack_slot    <= 1'b0;
            pend        <= 1'b0;
            sel         <= 1'b0;
            sda_low     <= 1'b0;
            commit      <= 1'b0;
            commit_data <= '0;
        end else begin
            commit <= 1'b0;
            if (evt.stop) begin
                commit   <= pend;
                phase    <= PH_IDLE;
                pend     <= 1'b0;
                sel      <= 1'b0;
                sda_low  <= 1'b0;
                ack_slot <= 1'b0;
                cnt      <= '0;
            end else if (evt.start) begin
                phase    <= PH_DEV;
                pend     <= 1'b0;
                sda_low  <= 1'b0;
                ack_slot <= 1'b0;
                cnt      <= '0;
            end else if (phase == PH_IDLE || phase == PH_SKIP) begin
                sda_low <= 1'b0;
            end else if (evt.rise && !ack_slot) begin
                if (cnt < FULL) begin
                    shreg <= {shreg[BYTE_W-2:0], evt.sda};
                    cnt   <= cnt + 1'b1;
                end
            end else if (evt.fall) begin
                if (ack_slot) begin
                    ack_slot <= 1'b0;
                    sda_low  <= 1'b0;
                    if (phase == PH_RDATA) begin
                        txbuf   <= rd_data;
                        sda_low <= ~rd_data[BYTE_W-1];
                    end else if (phase == PH_RDONE) begin
                        phase <= PH_IDLE;
                        sel   <= 1'b0;
                    end
                end else if (cnt == FULL) begin
                    cnt <= '0;
                    case (phase)
                        PH_DEV: begin
                            if (!dev_hit(shreg)) begin
                                phase   <= PH_SKIP;
                                sda_low <= 1'b0;
                            end else if (shreg[0]) begin
                                if (sel) begin
                                    phase    <= PH_RDATA;
                                    sda_low  <= 1'b1;
                                    ack_slot <= 1'b1;
                                end else begin
                                    phase   <= PH_SKIP;
                                    sda_low <= 1'b0;
                                end
                            end else begin
                                phase    <= PH_REG;
                                sda_low  <= 1'b1;
                                ack_slot <= 1'b1;
                            end
                        end
                        PH_REG: begin
                            if (shreg == SEL_CODE) begin
                                sel      <= 1'b1;
                                phase    <= PH_WDATA;
                                sda_low  <= 1'b1;
                                ack_slot <= 1'b1;
                            end else begin
                                phase   <= PH_SKIP;
                                sda_low <= 1'b0;
                            end
                        end
                        PH_WDATA: begin
                            pend        <= 1'b1;
                            commit_data <= shreg;
                            phase       <= PH_WEXTRA;
                            sda_low     <= 1'b1;
                            ack_slot    <= 1'b1;
                        end
                        PH_WEXTRA: begin
                            pend    <= 1'b0;
                            phase   <= PH_SKIP;
                            sda_low <= 1'b0;
                        end
                        PH_RDATA: begin
                            phase    <= PH_RDONE;
                            sda_low  <= 1'b0;
                            ack_slot <= 1'b1;
                        end
                        default: begin
                            phase   <= PH_SKIP;
                            sda_low <= 1'b0;
                        end
                    endcase
                end else if (phase == PH_RDATA && cnt != '0) begin
                    sda_low <= ~tx_bit(txbuf, cnt);
                end
            end
        end
    end

    // R4
    commit_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
        commit |-> $past(evt.stop));

    // R4
    commit_single_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);

    // R2
    sda_change_on_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_low) |-> $past(evt.fall || evt.start || evt.stop));

    // R8
    quiet_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE || phase == PH_SKIP) |-> !sda_low);

    // R5
    skip_no_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SKIP) |-> !pend);

    // R9
    read_no_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RDATA || phase == PH_RDONE) |-> !pend);

endmodule

// File: rtl/ctlreg_i2c_slave.sv
module ctlreg_i2c_slave
    import ctlreg_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              sda_pull_o,
    output logic              wr_commit_o,
    output logic [BYTE_W-1:0] wr_data_o
);
    logic [1:0] pins_s;
    bus_evt_t   evt;

    ctlreg_i2c_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_i, sda_i}),
        .q   (pins_s)
    );

    ctlreg_i2c_events u_evt (
        .clk   (clk),
        .rst   (rst),
        .scl_s (pins_s[1]),
        .sda_s (pins_s[0]),
        .evt   (evt)
    );

    ctlreg_i2c_engine u_eng (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .rd_data     (reg_rdata),
        .sda_low     (sda_pull_o),
        .commit      (wr_commit_o),
        .commit_data (wr_data_o)
    );
endmodule

// File: tb/tb_ctlreg_i2c_slave.sv
module tb_ctlreg_i2c_slave;
    localparam int CLK_PERIOD = 10;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic [7:0] rdval = 8'h00;
    logic sda_pull, commit;
    logic [7:0] wdata;
    wire sda_bus = m_sda & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctlreg_i2c_slave dut (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus),
        .reg_rdata(rdval), .sda_pull_o(sda_pull),
        .wr_commit_o(commit), .wr_data_o(wdata)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // behavioural model: 0 idle,1 dev,2 ptr,3 data,4 extra,5 read,6 ignore
    int m_st = 0;
    bit m_sel = 0, m_pend = 0;
    logic [7:0] m_pdata;
    logic [7:0] exp_q[$];

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mdl_start();
        m_st = 1; m_pend = 0;
    endtask

    task automatic mdl_stop();
        if (m_pend) exp_q.push_back(m_pdata);
        m_st = 0; m_pend = 0; m_sel = 0;
    endtask

    function automatic bit mdl_byte(logic [7:0] b);
        case (m_st)
            1: if (b[7:1] == 7'h52) begin
                   if (b[0]) begin
                       if (m_sel) begin m_st = 5; return 1; end
                       m_st = 6; return 0;
                   end
                   m_st = 2; return 1;
               end else begin m_st = 6; return 0; end
            2: if (b == 8'hFF) begin m_sel = 1; m_st = 3; return 1; end
               else begin m_st = 6; return 0; end
            3: begin m_pend = 1; m_pdata = b; m_st = 4; return 1; end
            4: begin m_pend = 0; m_st = 6; return 0; end
            default: return 0;
        endcase
    endfunction

    // every clock: a commit must match the model's queue
    always @(negedge clk) begin
        if (!rst && commit) begin
            if (exp_q.size() == 0)
                check(0, "R6", "unexpected commit", int'(wdata), 0);
            else
                check(wdata == exp_q[0], "R4", "commit data", int'(wdata), int'(exp_q[0]));
            if (exp_q.size() != 0) void'(exp_q.pop_front());
        end
    end

    task automatic clk_bit(bit b, output bit seen);
        tick(H/2); m_sda = b;
        tick(H/2); m_scl = 1;
        tick(H/2); seen = sda_bus;
        tick(H/2); m_scl = 0;
    endtask

    task automatic do_start();
        mdl_start();
        m_sda = 1; tick(H/2); m_scl = 1;
        tick(H/2); m_sda = 0;
        tick(H/2); m_scl = 0;
    endtask

    task automatic do_stop(string req);
        mdl_stop();
        tick(H/2); m_sda = 0;
        tick(H/2); m_scl = 1;
        tick(H/2); m_sda = 1;
        tick(H);
        check(exp_q.size() == 0, req, "commit after STOP", exp_q.size(), 0);
    endtask

    task automatic wbyte(logic [7:0] b, string req);
        bit seen, ack, eack;
        int clash = 0;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(b[i], seen);
            if (seen != b[i]) clash++;
        end
        eack = mdl_byte(b);
        clk_bit(1, seen);
        ack = !seen;
        check(clash == 0, req, "SDA released during master bits", clash, 0);
        check(ack == eack, req, $sformatf("ack for byte %02h", b), ack, eack);
    endtask

    task automatic rbyte(string req);
        bit seen;
        logic [7:0] got;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1, seen);
            got[i] = seen;
        end
        clk_bit(1, seen);
        m_st = 0; m_sel = 0;
        check(got == rdval, req, "read data", int'(got), int'(rdval));
    endtask

    initial begin
        tick(5);
        rst = 0;
        tick(3);
        // R10
        check(sda_pull == 0, "R10", "SDA released after reset", sda_pull, 0);
        check(commit == 0, "R10", "no commit after reset", commit, 0);
        m_scl = 0;

        // R2 R3 R4: plain write
        do_start(); wbyte(8'hA4, "R2"); wbyte(8'hFF, "R3"); wbyte(8'h5A, "R4"); do_stop("R4");
        do_start(); wbyte(8'hA4, "R2"); wbyte(8'hFF, "R3"); wbyte(8'h00, "R4"); do_stop("R4");
        do_start(); wbyte(8'hA4, "R2"); wbyte(8'hFF, "R3"); wbyte(8'hFF, "R4"); do_stop("R4");

        // R2: foreign device address
        do_start(); wbyte(8'hA6, "R2"); wbyte(8'hFF, "R2"); wbyte(8'h12, "R2"); do_stop("R2");

        // R3: wrong pointer
        do_start(); wbyte(8'hA4, "R3"); wbyte(8'h10, "R3"); wbyte(8'h34, "R3"); do_stop("R3");

        // R5: two data bytes abort
        do_start(); wbyte(8'hA4, "R5"); wbyte(8'hFF, "R5"); wbyte(8'h11, "R5"); wbyte(8'h22, "R5"); do_stop("R5");

        // R6: repeated START discards held byte
        do_start(); wbyte(8'hA4, "R6"); wbyte(8'hFF, "R6"); wbyte(8'h33, "R6");
        do_start(); wbyte(8'hA4, "R6"); wbyte(8'hFF, "R6"); wbyte(8'h44, "R6"); do_stop("R6");

        // R1: START in the middle of a byte
        begin
            bit s;
            do_start(); wbyte(8'hA4, "R1");
            clk_bit(1, s); clk_bit(0, s); clk_bit(1, s);
            do_start(); wbyte(8'hA4, "R1"); wbyte(8'hFF, "R1"); wbyte(8'h77, "R1"); do_stop("R1");
        end

        // R7 R9: random read
        rdval = 8'hC3;
        do_start(); wbyte(8'hA4, "R7"); wbyte(8'hFF, "R7");
        do_start(); wbyte(8'hA5, "R7"); rbyte("R7"); do_stop("R9");
        rdval = 8'h01;
        do_start(); wbyte(8'hA4, "R7"); wbyte(8'hFF, "R7");
        do_start(); wbyte(8'hA5, "R7"); rbyte("R7"); do_stop("R9");

        // R8: read without pointer refused
        do_start(); wbyte(8'hA5, "R8"); do_stop("R8");

        // R8: bytes after a finished read are ignored
        rdval = 8'h96;
        do_start(); wbyte(8'hA4, "R8"); wbyte(8'hFF, "R8");
        do_start(); wbyte(8'hA5, "R8"); rbyte("R8");
        wbyte(8'hA4, "R8"); wbyte(8'h00, "R8"); do_stop("R9");

        tick(10);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule